// File: doc/BRIEF.md
# Criticality-Driven Frequency Suggestion Controller

This block decides when a core should leave its nominal clock frequency at a barrier. At the end of each measurement interval it takes a sample of the criticality count of every core. The count for each core goes through a gate. The count must be above a programmable threshold, and the core must be running at the nominal level. If both hold, the count is looked up in a small range table. Each table row holds an upper count bound and a target frequency level. The lowest-indexed row whose bound is at least the count gives the suggested level.

A suggestion does not act on the clock at once. It goes to a per-core confidence filter. The filter keeps one 2-bit saturating counter for each target level. The counter for the suggested level rises, and the counters for all other levels fall. A one-cycle command strobe is raised, with the level, only when the counter for a target reaches its top value. Issuing a command clears every confidence counter of that core. With this filter, a single noisy interval cannot cause a frequency change.

There are four levels, and level 0 is nominal. Software fills the range table through a write port. After reset every row has bound 0 and level 0.

Top module: `dvfs_suggest_top`

## Requirements
- R1: After reset, no command strobe is raised. Every table row holds bound 0 and level 0, so no positive count matches any row.
- R2: A count that is less than or equal to the threshold gives no suggestion, however many samples repeat it.
- R3: A core whose current level is not 0 (nominal) gets no suggestion.
- R4: The suggested level is taken from the lowest-indexed row whose bound is greater than or equal to the count. Row index 0 has the highest priority.
- R5: A count above the bound of every row gives no suggestion.
- R6: When the same level is suggested on three samples in a row, starting from cleared confidence, the core's command strobe goes high. It rises in the cycle after the third sample strobe, for exactly one cycle, and carries that level.
- R7: Each sample that suggests a different level, or no level, lowers the confidence of every other level by one (not below 0). The count needed before a switch grows to match.
- R8: Issuing a command clears all confidence counters of that core. A further three matching samples are then needed before the next command.
- R9: Each core is filtered on its own. Cores may issue commands in the same cycle, each with its own level.
- R10: A table write applies to samples taken in later cycles.
- R11: A command strobe appears only in the cycle after a sample strobe, and it never carries level 0.
- R12: A matching row whose level equals the core's current level (0) gives no suggestion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Interval-end strobe; all counts are sampled in this cycle |
| critCounts | input | NUM_CORES*CNT_W | Criticality count of each core, core 0 in the low bits |
| curLevels | input | NUM_CORES*LVL_W | Present frequency level of each core, core 0 in the low bits |
| threshold | input | CNT_W | A count must exceed this value before the table is consulted |
| tblWrEn | input | 1 | Table row write strobe |
| tblWrIdx | input | IDX_W | Row written |
| tblWrBound | input | CNT_W | Upper count bound for the row |
| tblWrLevel | input | LVL_W | Target level for the row |
| cmdValid | output | NUM_CORES | One-cycle command strobe per core |
| cmdLevels | output | NUM_CORES*LVL_W | Commanded level per core; it holds its value between strobes |

## Verification
Counts are placed inside each row's range to show that the row priority picks the right level. Counts equal to the threshold, counts above every bound, and counts that hit a row set to the nominal level show that the gate and the no-change check block a suggestion where they should. Interleaved sequences such as same, same, other, same and same, same, none, same are applied to tell a true decay of confidence apart from a simple count of matches. Two cores given different ranges in the same samples show that per-core state does not mix.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef struct packed {
    logic loadEntry;   // write one table row this cycle
    logic evalSample;  // evaluate counts and update confidence this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/dvfs_ctrl.sv
module dvfs_ctrl
  import dvfs_pkg::*;
(
  input  logic        sampleValid,
  input  logic        tblWrEn,
  output ctrlStrobe_t strobes
);
  always_comb begin
    strobes.loadEntry  = tblWrEn;
    strobes.evalSample = sampleValid;
  end
endmodule

// File: rtl/dvfs_lookup.sv
module dvfs_lookup
  import dvfs_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 14,
  parameter int LVL_W     = 2,
  parameter int ENTRIES   = 4,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobes,
  input  logic [IDX_W-1:0]           tblWrIdx,
  input  logic [CNT_W-1:0]           tblWrBound,
  input  logic [LVL_W-1:0]           tblWrLevel,
  input  logic [NUM_CORES*CNT_W-1:0] critCounts,
  input  logic [NUM_CORES*LVL_W-1:0] curLevels,
  input  logic [CNT_W-1:0]           threshold,
  output logic [NUM_CORES-1:0]       sugValid,
  output logic [NUM_CORES*LVL_W-1:0] sugLevels
);
  logic [CNT_W-1:0] boundMem [ENTRIES];
  logic [LVL_W-1:0] levelMem [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        boundMem[e] <= '0;
        levelMem[e] <= '0;
      end
    end else if (strobes.loadEntry) begin
      boundMem[tblWrIdx] <= tblWrBound;
      levelMem[tblWrIdx] <= tblWrLevel;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : gCore
    logic [CNT_W-1:0] cnt;
    logic [LVL_W-1:0] cur;
    logic             hit;
    logic [LVL_W-1:0] hitLevel;

    assign cnt = critCounts[c*CNT_W +: CNT_W];
    assign cur = curLevels[c*LVL_W +: LVL_W];

    always_comb begin
      hit      = 1'b0;
      hitLevel = '0;
      // scan from the top so the lowest matching index wins
      for (int e = ENTRIES - 1; e >= 0; e--) begin
        if (boundMem[e] >= cnt) begin
          hit      = 1'b1;
          hitLevel = levelMem[e];
        end
      end
    end

    assign sugValid[c] = (cnt > threshold) && (cur == '0) && hit && (hitLevel != cur);
    assign sugLevels[c*LVL_W +: LVL_W] = hitLevel;
  end
endmodule

// File: rtl/dvfs_conf.sv
module dvfs_conf
  import dvfs_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LVL_W     = 2,
  parameter int CONF_W    = 2,
  localparam int NUM_LVLS = 2 ** LVL_W,
  localparam int CONF_TOP = (2 ** CONF_W) - 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobes,
  input  logic [NUM_CORES-1:0]       sugValid,
  input  logic [NUM_CORES*LVL_W-1:0] sugLevels,
  output logic [NUM_CORES-1:0]       cmdValid,
  output logic [NUM_CORES*LVL_W-1:0] cmdLevels
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : gCore
    logic [CONF_W-1:0] conf [NUM_LVLS];
    logic [LVL_W-1:0]  sugLvl;
    logic              promote;

    assign sugLvl  = sugLevels[c*LVL_W +: LVL_W];
    assign promote = sugValid[c] && (conf[sugLvl] == CONF_W'(CONF_TOP - 1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int l = 0; l < NUM_LVLS; l++) conf[l] <= '0;
        cmdValid[c]                 <= 1'b0;
        cmdLevels[c*LVL_W +: LVL_W] <= '0;
      end else begin
        cmdValid[c] <= 1'b0;
        if (strobes.evalSample) begin
          if (promote) begin
            cmdValid[c]                 <= 1'b1;
            cmdLevels[c*LVL_W +: LVL_W] <= sugLvl;
            for (int l = 0; l < NUM_LVLS; l++) conf[l] <= '0;
          end else begin
            for (int l = 0; l < NUM_LVLS; l++) begin
              if (sugValid[c] && (LVL_W'(l) == sugLvl)) conf[l] <= conf[l] + 1'b1;
              else if (conf[l] != '0)                   conf[l] <= conf[l] - 1'b1;
            end
          end
        end
      end
    end

    AST_CMD_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
      cmdValid[c] |-> $past(strobes.evalSample)); // R11
    AST_CMD_NOT_NOMINAL: assert property (@(posedge clk) disable iff (!rstN)
      cmdValid[c] |-> (cmdLevels[c*LVL_W +: LVL_W] != '0)); // R11
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
      cmdValid[c] |=> !cmdValid[c]); // R8
  end
endmodule

// File: rtl/dvfs_suggest_top.sv
module dvfs_suggest_top
  import dvfs_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 14,
  parameter int LVL_W     = 2,
  parameter int ENTRIES   = 4,
  parameter int CONF_W    = 2,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic [NUM_CORES*CNT_W-1:0] critCounts,
  input  logic [NUM_CORES*LVL_W-1:0] curLevels,
  input  logic [CNT_W-1:0]           threshold,
  input  logic                       tblWrEn,
  input  logic [IDX_W-1:0]           tblWrIdx,
  input  logic [CNT_W-1:0]           tblWrBound,
  input  logic [LVL_W-1:0]           tblWrLevel,
  output logic [NUM_CORES-1:0]       cmdValid,
  output logic [NUM_CORES*LVL_W-1:0] cmdLevels
);
  ctrlStrobe_t                strobes;
  logic [NUM_CORES-1:0]       sugValid;
  logic [NUM_CORES*LVL_W-1:0] sugLevels;

  dvfs_ctrl uCtrl (
    .sampleValid (sampleValid),
    .tblWrEn     (tblWrEn),
    .strobes     (strobes)
  );

  dvfs_lookup #(
    .NUM_CORES (NUM_CORES),
    .CNT_W     (CNT_W),
    .LVL_W     (LVL_W),
    .ENTRIES   (ENTRIES)
  ) uLookup (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .tblWrIdx   (tblWrIdx),
    .tblWrBound (tblWrBound),
    .tblWrLevel (tblWrLevel),
    .critCounts (critCounts),
    .curLevels  (curLevels),
    .threshold  (threshold),
    .sugValid   (sugValid),
    .sugLevels  (sugLevels)
  );

  dvfs_conf #(
    .NUM_CORES (NUM_CORES),
    .LVL_W     (LVL_W),
    .CONF_W    (CONF_W)
  ) uConf (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sugValid  (sugValid),
    .sugLevels (sugLevels),
    .cmdValid  (cmdValid),
    .cmdLevels (cmdLevels)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : gChk
    AST_GATE_THRESHOLD: assert property (@(posedge clk) disable iff (!rstN)
      cmdValid[c] |-> $past(critCounts[c*CNT_W +: CNT_W] > threshold)); // R2
    AST_GATE_NOMINAL: assert property (@(posedge clk) disable iff (!rstN)
      cmdValid[c] |-> $past(curLevels[c*LVL_W +: LVL_W] == '0)); // R3
  end
endmodule

// File: tb/tb_dvfs_suggest_top.sv
module tb_dvfs_suggest_top;
  localparam int NC = 4, CW = 14, LW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [NC*CW-1:0] critCounts = '0;
  logic [NC*LW-1:0] curLevels = '0;
  logic [CW-1:0] threshold = '0;
  logic tblWrEn = 1'b0;
  logic [1:0] tblWrIdx = '0;
  logic [CW-1:0] tblWrBound = '0;
  logic [LW-1:0] tblWrLevel = '0;
  logic [NC-1:0] cmdValid;
  logic [NC*LW-1:0] cmdLevels;

  int checks = 0, failures = 0;

  always #4 clk = ~clk; // 125 MHz

  dvfs_suggest_top dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeRow(int idx, int bound, int lvl);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrIdx = idx[1:0]; tblWrBound = bound[CW-1:0]; tblWrLevel = lvl[LW-1:0];
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  // apply one sample with core0/core1 counts; others idle; strobe visible at the returned negedge
  task automatic sample(int c0, int c1, int lvl0);
    @(negedge clk);
    critCounts = '0;
    critCounts[0 +: CW] = c0[CW-1:0];
    critCounts[CW +: CW] = c1[CW-1:0];
    curLevels = '0;
    curLevels[0 +: LW] = lvl0[LW-1:0];
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic flush();
    sample(0, 0, 0);
    sample(0, 0, 0);
    sample(0, 0, 0);
  endtask

  task automatic testReset();
    check("R1 strobe after reset", cmdValid, 4'b0);
    threshold = '0;
    for (int i = 0; i < 3; i++) begin
      sample(10, 10, 0);
      check("R1 empty table gives no command", cmdValid, 4'b0);
    end
  endtask

  task automatic testIssue();
    sample(80, 0, 0);
    check("R6 no strobe after first", cmdValid, 4'b0);
    sample(80, 0, 0);
    check("R6 no strobe after second", cmdValid, 4'b0);
    sample(80, 0, 0);
    check("R6 strobe after third", cmdValid, 4'b0001);
    check("R6 level row0", cmdLevels[0 +: LW], 2'd3);
    @(negedge clk);
    check("R6 strobe lasts one cycle", cmdValid, 4'b0);
    check("R10 programmed rows used", cmdLevels[0 +: LW], 2'd3);
  endtask

  task automatic testClearAfterIssue();
    sample(80, 0, 0);
    check("R8 no strobe first after issue", cmdValid, 4'b0);
    sample(80, 0, 0);
    check("R8 no strobe second after issue", cmdValid, 4'b0);
    sample(80, 0, 0);
    check("R8 strobe third after issue", cmdValid, 4'b0001);
  endtask

  task automatic testPriorityAndCores();
    flush();
    for (int i = 0; i < 2; i++) begin
      sample(150, 250, 0);
      check("R9 no early strobe", cmdValid, 4'b0);
    end
    sample(150, 250, 0);
    check("R9 both cores strobe", cmdValid, 4'b0011);
    check("R4 core0 range row1", cmdLevels[0 +: LW], 2'd2);
    check("R4 core1 range row2", cmdLevels[LW +: LW], 2'd1);
  endtask

  task automatic testNoSuggest(string req, int c0, int lvl0);
    flush();
    for (int i = 0; i < 4; i++) begin
      sample(c0, 0, lvl0);
      check(req, cmdValid, 4'b0);
    end
  endtask

  task automatic testDecay();
    flush();
    sample(80, 0, 0); sample(80, 0, 0);
    sample(150, 0, 0);
    check("R7 other target no strobe", cmdValid, 4'b0);
    sample(80, 0, 0);
    check("R7 decayed confidence no strobe", cmdValid, 4'b0);
    sample(80, 0, 0);
    check("R7 strobe after rebuild", cmdValid, 4'b0001);
    check("R7 level", cmdLevels[0 +: LW], 2'd3);
    sample(80, 0, 0); sample(80, 0, 0);
    sample(10, 0, 0);
    check("R7 no-suggestion sample no strobe", cmdValid, 4'b0);
    sample(80, 0, 0);
    check("R7 decayed by empty sample", cmdValid, 4'b0);
    sample(80, 0, 0);
    check("R7 strobe after empty decay", cmdValid, 4'b0001);
  endtask

  task automatic testRewrite();
    flush();
    writeRow(0, 100, 1);
    for (int i = 0; i < 3; i++) sample(80, 0, 0);
    check("R10 rewritten row strobe", cmdValid, 4'b0001);
    check("R10 rewritten row level", cmdLevels[0 +: LW], 2'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    threshold = 14'd50;
    writeRow(0, 100, 3);
    writeRow(1, 200, 2);
    writeRow(2, 300, 1);
    writeRow(3, 400, 0);
    testIssue();
    testClearAfterIssue();
    testPriorityAndCores();
    testNoSuggest("R2 count equal to threshold", 50, 0);
    testNoSuggest("R3 core off nominal", 80, 1);
    testNoSuggest("R12 row level equals current", 350, 0);
    testNoSuggest("R5 count above all bounds", 500, 0);
    testDecay();
    testRewrite();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule